// File: doc/BRIEF.md
# Fixed-Priority Four-by-Four Bus Arbiter

This block joins four bus masters (an instruction fetch port, a data read port on the code space, a system bus port and a DMA engine) to four slave ports (code flash, ROM, SRAM and peripherals). Each master presents one request at a time: a valid bit, a two-bit slave select and an address. The block checks every request against a sparse permission matrix and a set of security rules.

A request that is not allowed is answered at once with ready and error in the same cycle, and it never reaches a slave. An allowed request waits for its slave. Each slave has its own fixed ranking of the masters that may use it, and the ranking never rotates. The winner holds the slave until the slave signals completion.

While a slave is granted, the block drives the slave's valid, address and owner index. The slave's done pulse is returned to the owning master as ready, with no error.

Top module: `fixprio_xbar`

## Requirements
- R1: After reset, and until a request is granted, every slave valid and every master ready is low.
- R2: A legal request to an idle slave is granted at the next clock edge. From then on, the slave valid is high, the slave owner is the master index (fetch=0, data=1, system=2, DMA=3) and the slave address equals that master's address.
- R3: On the flash slave (select 0), DMA beats the data port, and the data port beats the fetch port.
- R4: On the ROM slave (select 1), the data port beats the fetch port.
- R5: On the SRAM slave (select 2), DMA beats the system port, and the system port beats the data port.
- R6: On the peripheral slave (select 3), DMA beats the system port.
- R7: A request outside the permission matrix raises ready and error in the same cycle and is never forwarded. The pairs outside the matrix are fetch to SRAM or peripherals, data port to peripherals, system port to flash or ROM, and DMA to ROM.
- R8: When secure mode and IP protection are both on, a DMA flash access with address bit 17 clear (bank 0) is answered with an error. With bit 17 set, or with IP protection off, the access is granted.
- R9: When secure mode and the data-port flash lock are both on, a data-port flash access is answered with an error.
- R10: A DMA access to SRAM with address bit 29 clear (the code-space alias) is answered with an error. With bit 29 set (system space), it is granted.
- R11: A grant stays with its owner until the slave's done. A higher-ranked request that arrives meanwhile does not take the slave. The owner's ready is raised, without error, in the same cycle as done.
- R12: In the cycle after done, the slave valid is low. The next arbitration takes effect one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sec_mode | input | 1 | Secure mode enable |
| sec_ip_prot | input | 1 | IP protection on (restricts DMA flash access to bank 1) |
| sec_dlock | input | 1 | Blocks data-port flash access in secure mode |
| m_valid | input | 4 | Request valid, one bit per master |
| m_sel | input | 8 | Slave select, 2 bits per master |
| m_addr | input | 128 | Request address, 32 bits per master |
| m_ready | output | 4 | Transfer complete, one bit per master |
| m_err | output | 4 | Error response, valid with ready |
| s_valid | output | 4 | Slave granted, one bit per slave |
| s_addr | output | 128 | Owner's address, 32 bits per slave |
| s_owner | output | 8 | Owning master index, 2 bits per slave |
| s_done | input | 4 | Slave completes its transfer |

## Verification
Error responses are combinational, so each error check is made one settle delay after the stimulus is driven, before any clock edge. Grants are registered once: the bench drives a request just after an edge and checks slave valid, owner and address just after the following edge. Ready for a granted master is checked in the same cycle that done is driven. Slave valid is checked low one edge after done, and the next winner is checked one edge later still.

// File: rtl/arb_pkg.sv
package arb_pkg;
    localparam int NM = 4;
    localparam int NS = 4;
    localparam int MW = $clog2(NM);
    localparam int SW = $clog2(NS);
    localparam int NO_ACCESS = NM;

    localparam int M_FETCH = 0;
    localparam int M_DATA  = 1;
    localparam int M_SYS   = 2;
    localparam int M_DMA   = 3;

    localparam int S_FLASH = 0;
    localparam int S_ROM   = 1;
    localparam int S_SRAM  = 2;
    localparam int S_PERI  = 3;

    // Rank of a master on a slave: 0 wins; NO_ACCESS means not permitted.
    function automatic int rank_of(int slv, int mst);
        int r;
        r = NO_ACCESS;
        case (slv)
            S_FLASH: case (mst)
                M_DMA: r = 0; M_DATA: r = 1; M_FETCH: r = 2; default: r = NO_ACCESS;
            endcase
            S_ROM: case (mst)
                M_DATA: r = 0; M_FETCH: r = 1; default: r = NO_ACCESS;
            endcase
            S_SRAM: case (mst)
                M_DMA: r = 0; M_SYS: r = 1; M_DATA: r = 2; default: r = NO_ACCESS;
            endcase
            S_PERI: case (mst)
                M_DMA: r = 0; M_SYS: r = 1; default: r = NO_ACCESS;
            endcase
            default: r = NO_ACCESS;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/xbar_gate.sv
module xbar_gate
    import arb_pkg::*;
#(
    parameter int MST      = 0,
    parameter int AW       = 32,
    parameter int BANK_BIT = 17,
    parameter int SYS_BIT  = 29
) (
    input  logic          valid,
    input  logic [SW-1:0] sel,
    input  logic [AW-1:0] addr,
    input  logic          sec_mode,
    input  logic          sec_ip_prot,
    input  logic          sec_dlock,
    output logic          legal,
    output logic          err
);
    logic allow, block;

    always_comb begin
        allow = (rank_of(int'(sel), MST) != NO_ACCESS);
        block = 1'b0;
        if (MST == M_DMA && int'(sel) == S_FLASH && sec_mode && sec_ip_prot && !addr[BANK_BIT])
            block = 1'b1;
        if (MST == M_DATA && int'(sel) == S_FLASH && sec_mode && sec_dlock)
            block = 1'b1;
        if (MST == M_DMA && int'(sel) == S_SRAM && !addr[SYS_BIT])
            block = 1'b1;
        legal = valid && allow && !block;
        err   = valid && !(allow && !block);
    end
endmodule

// File: rtl/xbar_slot.sv
module xbar_slot
    import arb_pkg::*;
#(
    parameter int SLV = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NM-1:0] cand,
    input  logic          done,
    output logic          busy,
    output logic [MW-1:0] owner
);
    typedef struct packed {
        logic          busy;
        logic [MW-1:0] owner;
    } slot_t;

    slot_t state_d, state_q;
    int            best;
    logic          found;
    logic [MW-1:0] pick;

    always_comb begin
        state_d = state_q;
        best    = NO_ACCESS;
        found   = 1'b0;
        pick    = '0;
        for (int m = 0; m < NM; m++) begin
            if (cand[m] && rank_of(SLV, m) < best) begin
                best  = rank_of(SLV, m);
                found = 1'b1;
                pick  = MW'(m);
            end
        end
        if (state_q.busy) begin
            if (done) state_d.busy = 1'b0;
        end else if (found) begin
            state_d.busy  = 1'b1;
            state_d.owner = pick;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign busy  = state_q.busy;
    assign owner = state_q.owner;
endmodule

// File: rtl/fixprio_xbar.sv
module fixprio_xbar
    import arb_pkg::*;
#(
    parameter int AW       = 32,
    parameter int BANK_BIT = 17,
    parameter int SYS_BIT  = 29
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sec_mode,
    input  logic             sec_ip_prot,
    input  logic             sec_dlock,
    input  logic [NM-1:0]    m_valid,
    input  logic [NM*SW-1:0] m_sel,
    input  logic [NM*AW-1:0] m_addr,
    output logic [NM-1:0]    m_ready,
    output logic [NM-1:0]    m_err,
    output logic [NS-1:0]    s_valid,
    output logic [NS*AW-1:0] s_addr,
    output logic [NS*MW-1:0] s_owner,
    input  logic [NS-1:0]    s_done
);
    logic [NM-1:0] legal;
    logic [NM-1:0] cand [NS];
    logic [NS-1:0] busy;
    logic [MW-1:0] own [NS];

    for (genvar m = 0; m < NM; m++) begin : g_mst
        xbar_gate #(.MST(m), .AW(AW), .BANK_BIT(BANK_BIT), .SYS_BIT(SYS_BIT)) u_gate (
            .valid       (m_valid[m]),
            .sel         (m_sel[m*SW +: SW]),
            .addr        (m_addr[m*AW +: AW]),
            .sec_mode    (sec_mode),
            .sec_ip_prot (sec_ip_prot),
            .sec_dlock   (sec_dlock),
            .legal       (legal[m]),
            .err         (m_err[m])
        );
    end

    always_comb begin
        for (int s = 0; s < NS; s++)
            for (int m = 0; m < NM; m++)
                cand[s][m] = legal[m] && (m_sel[m*SW +: SW] == SW'(s));
    end

    for (genvar s = 0; s < NS; s++) begin : g_slv
        xbar_slot #(.SLV(s)) u_slot (
            .clk   (clk),
            .rst_n (rst_n),
            .cand  (cand[s]),
            .done  (s_done[s]),
            .busy  (busy[s]),
            .owner (own[s])
        );
        assign s_valid[s]           = busy[s];
        assign s_owner[s*MW +: MW]  = own[s];
        assign s_addr[s*AW +: AW]   = m_addr[int'(own[s])*AW +: AW];
    end

    always_comb begin
        for (int m = 0; m < NM; m++) begin
            logic [SW-1:0] sl;
            sl = m_sel[m*SW +: SW];
            m_ready[m] = m_err[m] ||
                         (busy[sl] && own[sl] == MW'(m) && s_done[sl]);
        end
    end
endmodule

// File: rtl/fixprio_xbar_chk.sv
module fixprio_xbar_chk
    import arb_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [NM-1:0]    m_valid,
    input logic [NM-1:0]    m_ready,
    input logic [NM-1:0]    m_err,
    input logic [NS-1:0]    s_valid,
    input logic [NS*MW-1:0] s_owner,
    input logic [NS-1:0]    s_done
);
    for (genvar m = 0; m < NM; m++) begin : g_m
        // R7: an error is a completed response for a live request
        p_err_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
            m_err[m] |-> (m_ready[m] && m_valid[m]));
    end

    for (genvar s = 0; s < NS; s++) begin : g_s
        // R2/R7: a slave only serves a live, non-erroring request of its owner
        p_owner_live_r2: assert property (@(posedge clk) disable iff (!rst_n)
            s_valid[s] |-> (m_valid[s_owner[s*MW +: MW]] && !m_err[s_owner[s*MW +: MW]]));
        // R11: grant held until done
        p_grant_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (s_valid[s] && !s_done[s]) |=> (s_valid[s] && $stable(s_owner[s*MW +: MW])));
        // R11: done returns ready to the owner
        p_done_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (s_valid[s] && s_done[s]) |-> m_ready[s_owner[s*MW +: MW]]);
        // R12: slave idles for a cycle after completion
        p_idle_after_r12: assert property (@(posedge clk) disable iff (!rst_n)
            (s_valid[s] && s_done[s]) |=> !s_valid[s]);
    end
endmodule

bind fixprio_xbar fixprio_xbar_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .m_valid (m_valid),
    .m_ready (m_ready),
    .m_err   (m_err),
    .s_valid (s_valid),
    .s_owner (s_owner),
    .s_done  (s_done)
);

// File: tb/fixprio_xbar_test.sv
module fixprio_xbar_test;
    localparam int PER = 10;
    localparam int AW  = 32;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           sec_mode = 1'b0, sec_ip_prot = 1'b0, sec_dlock = 1'b0;
    logic [3:0]     m_valid = '0;
    logic [7:0]     m_sel = '0;
    logic [4*AW-1:0] m_addr = '0;
    logic [3:0]     m_ready, m_err, s_valid, s_done = '0;
    logic [4*AW-1:0] s_addr;
    logic [7:0]     s_owner;

    int tests = 0, fails = 0;

    fixprio_xbar uut (.*);

    always #(PER/2) clk = ~clk;

    task automatic chk(string tag, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic req(int m, int slv, logic [AW-1:0] a);
        m_valid[m] = 1'b1;
        m_sel[m*2 +: 2] = 2'(slv);
        m_addr[m*AW +: AW] = a;
    endtask

    function automatic int own(int s);
        return int'(s_owner[s*2 +: 2]);
    endfunction

    // Grant on next edge, complete, then confirm idle cycle (R2, R11, R12)
    task automatic serve(int slv, int exp_m, string tag);
        tick();
        chk({tag, " valid"}, int'(s_valid[slv]), 1);
        chk({tag, " owner"}, own(slv), exp_m);
        s_done[slv] = 1'b1; #1;
        chk({tag, " R11 ready"}, int'(m_ready[exp_m]), 1);
        chk({tag, " R11 no err"}, int'(m_err[exp_m]), 0);
        tick();
        s_done[slv] = 1'b0;
        m_valid[exp_m] = 1'b0; #1;
        chk({tag, " R12 idle"}, int'(s_valid[slv]), 0);
    endtask

    task automatic expect_err(int m, int slv, logic [AW-1:0] a, string tag);
        req(m, slv, a); #1;
        chk({tag, " ready"}, int'(m_ready[m]), 1);
        chk({tag, " err"}, int'(m_err[m]), 1);
        tick();
        chk({tag, " not forwarded"}, int'(s_valid[slv]), 0);
        m_valid[m] = 1'b0; #1;
    endtask

    task automatic t_reset();
        chk("R1 s_valid", int'(s_valid), 0);
        chk("R1 m_ready", int'(m_ready), 0);
    endtask

    task automatic t_single();
        req(0, 0, 32'h0000_1234);
        tick();
        chk("R2 valid", int'(s_valid[0]), 1);
        chk("R2 owner", own(0), 0);
        chk("R2 addr", int'(s_addr[0 +: AW]), 32'h1234);
        s_done[0] = 1'b1; #1;
        chk("R11 ready", int'(m_ready[0]), 1);
        tick(); s_done[0] = 1'b0; m_valid[0] = 1'b0; #1;
        chk("R12 idle", int'(s_valid[0]), 0);
    endtask

    task automatic t_flash_prio();
        req(0, 0, 32'h100); req(1, 0, 32'h200); req(3, 0, 32'h300);
        serve(0, 3, "R3 dma first");
        serve(0, 1, "R3 data second");
        serve(0, 0, "R3 fetch last");
    endtask

    task automatic t_rom_prio();
        req(0, 1, 32'h0200_0800); req(1, 1, 32'h0200_0900);
        serve(1, 1, "R4 data first");
        serve(1, 0, "R4 fetch last");
    endtask

    task automatic t_sram_prio();
        req(1, 2, 32'h2000_0010); req(2, 2, 32'h2000_0020); req(3, 2, 32'h2000_0030);
        serve(2, 3, "R5 dma first");
        serve(2, 2, "R5 sys second");
        serve(2, 1, "R5 data last");
    endtask

    task automatic t_peri_prio();
        req(2, 3, 32'h4000_0000); req(3, 3, 32'h4000_0004);
        serve(3, 3, "R6 dma first");
        serve(3, 2, "R6 sys last");
    endtask

    task automatic t_perm();
        expect_err(0, 2, 32'h2000_0000, "R7 fetch-sram");
        expect_err(0, 3, 32'h4000_0000, "R7 fetch-peri");
        expect_err(1, 3, 32'h4000_0000, "R7 data-peri");
        expect_err(2, 0, 32'h0000_0000, "R7 sys-flash");
        expect_err(2, 1, 32'h0200_0800, "R7 sys-rom");
        expect_err(3, 1, 32'h0200_0800, "R7 dma-rom");
    endtask

    task automatic t_dma_bank();
        sec_mode = 1'b1; sec_ip_prot = 1'b1;
        expect_err(3, 0, 32'h0000_1000, "R8 bank0 blocked");
        req(3, 0, 32'h0002_0000); #1;
        chk("R8 bank1 no err", int'(m_err[3]), 0);
        serve(0, 3, "R8 bank1 granted");
        sec_ip_prot = 1'b0;
        req(3, 0, 32'h0000_1000);
        serve(0, 3, "R8 no ip bank0 granted");
        sec_mode = 1'b0;
    endtask

    task automatic t_dlock();
        sec_mode = 1'b1; sec_dlock = 1'b1;
        expect_err(1, 0, 32'h0000_0040, "R9 data locked");
        sec_mode = 1'b0;
        req(1, 0, 32'h0000_0040);
        serve(0, 1, "R9 unlocked outside secure");
        sec_dlock = 1'b0;
    endtask

    task automatic t_alias();
        expect_err(3, 2, 32'h0100_0010, "R10 code alias");
        req(3, 2, 32'h2000_0010);
        serve(2, 3, "R10 system space");
    endtask

    task automatic t_hold();
        req(0, 0, 32'h0000_0080);
        tick();
        chk("R11 fetch owns", own(0), 0);
        req(3, 0, 32'h0002_0080);
        tick();
        chk("R11 still fetch", own(0), 0);
        chk("R11 dma waits", int'(m_ready[3]), 0);
        s_done[0] = 1'b1; #1;
        chk("R11 fetch ready", int'(m_ready[0]), 1);
        tick(); s_done[0] = 1'b0; m_valid[0] = 1'b0; #1;
        chk("R12 idle after hold", int'(s_valid[0]), 0);
        serve(0, 3, "R11 dma after");
    endtask

    initial begin
        #(PER * 100000);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(PER * 2 + 1);
        t_reset();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_single();
        t_flash_prio();
        t_rom_prio();
        t_sram_prio();
        t_peri_prio();
        t_perm();
        t_dma_bank();
        t_dlock();
        t_alias();
        t_hold();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule